// File: doc/BRIEF.md
# Serial Frame Check Sequence Engine

This block works out a cyclic redundancy check one bit per clock. It keeps an r-cell register that moves toward its most significant end. The divisor polynomial sets XOR feedback taps into that register. Both r and the divisor are parameters, so one body of code serves any width and any generator. Typical choices are the 12-bit, the two 16-bit and the 32-bit polynomials. The divisor parameter holds every coefficient below the leading term, and bit i of it is the coefficient of x^i.

To generate a check sequence, the user clears the register and shifts in the k message bits, most significant bit first. Then the user shifts in r zero bits. The register now holds the r-bit remainder of the message times x^r divided by the divisor, leading zeros included. That remainder is the check sequence, and it is sent after the message.

To check a received frame, the user clears the register and shifts in all k + r received bits in the same order. If the register ends at zero, no error was detected. The zero flag reports this without waiting for a clock edge. The register always starts at zero and is never inverted on the way out.

Top module: `serial_fcs_engine`

## Requirements
- R1: Asynchronous reset (`rst_n` low) leaves the remainder at zero. A synchronous clear (`clr` high at a rising edge) also leaves the remainder at zero.
- R2: While `clr` and `bit_vld` are both low, the remainder keeps its value, whatever `bit_in` does.
- R3: When `clr` and `bit_vld` are high in the same cycle, the clear wins, and the remainder is zero after that edge.
- R4: On a valid bit with remainder bit r-1 at 0, the remainder shifts one place toward bit r-1, and `bit_in` enters bit 0.
- R5: On a valid bit with remainder bit r-1 at 1, the value shifted in the R4 manner is XORed with the divisor parameter. This includes bit 0, whose coefficient is always 1. After any bit stream from a cleared state, the remainder therefore equals that stream, read most significant bit first, modulo the full divisor.
- R6: Feeding a message and then r zeros leaves the check sequence in the register. With r = 5, divisor 110101 and message 1010001101, the remainder reads 01110, with bit 4 on the left.
- R7: Feeding a whole valid frame, meaning the message followed by its check sequence, leaves the remainder at zero. For the divisor in R6 that frame is 101000110101110.
- R8: With r = 4 and divisor x^4+x^3+1 (parameter 1001), flipping any single bit of a valid 15-bit code word leaves a nonzero remainder.
- R9: `rem_zero` is high exactly when all bits of `rem_out` are zero. It follows the register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear before a frame; takes priority over a bit |
| bit_vld | input | 1 | A serial bit is present this cycle |
| bit_in | input | 1 | Serial data, most significant bit first |
| rem_out | output | WIDTH | Current register contents (remainder) |
| rem_zero | output | 1 | High while the register is all zero |

## Verification
The hardest case to reach from the ports is a frame that is wrong yet still close to valid. The register must end at zero for every valid frame and at a nonzero value for every single-bit corruption of one.

The bench builds these frames in its own arithmetic. It takes each 10-bit message for the 5-bit divisor and a spread of 11-bit messages for the 4-bit divisor. It appends the check sequence from a long-division function, and for the 4-bit divisor it also flips each bit position in turn.

The register is also compared after every single bit against the remainder of the prefix fed so far. This makes the feedback path show itself in the middle of a frame, not only at its end.

// File: rtl/serial_fcs_engine.sv
module serial_fcs_engine #(
  parameter int          WIDTH = 16,
  parameter logic [WIDTH-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [WIDTH-1:0] rem_out,
  output logic             rem_zero
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] cells;
  logic [WIDTH-1:0] cells_nxt;
  logic             fb;

  assign fb = cells[MSB];

  // C0 always takes the feedback: the constant term of the divisor is 1.
  assign cells_nxt[0] = bit_in ^ fb;

  for (genvar i = 1; i < WIDTH; i++) begin : g_tap
    if (POLY[i]) begin : g_xor
      assign cells_nxt[i] = cells[i-1] ^ fb;
    end else begin : g_wire
      assign cells_nxt[i] = cells[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cells <= '0;
    else if (clr)     cells <= '0;
    else if (bit_vld) cells <= cells_nxt;
  end

  assign rem_out  = cells;
  assign rem_zero = ~|cells;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem_out == '0));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_vld) |=> $stable(rem_out));

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && bit_vld && bit_in) |=> rem_zero);

  p_plain_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && !rem_out[MSB]) |=>
      (rem_out == {$past(rem_out[MSB-1:0]), $past(bit_in)}));

  p_feedback_c0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && rem_out[MSB]) |=> (rem_out[0] == !$past(bit_in)));

  p_zero_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_vld && rem_zero && !bit_in) |=> rem_zero);

endmodule

// File: tb/serial_fcs_engine_tb_top.sv
`timescale 1ns/1ps
module serial_fcs_engine_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic a_clr, a_vld, a_din;
  logic b_clr, b_vld, b_din;
  logic [4:0] a_rem;
  logic [3:0] b_rem;
  logic a_zero, b_zero;

  int checks = 0;
  int errors = 0;

  serial_fcs_engine #(.WIDTH(5), .POLY(5'b10101)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .bit_vld(a_vld), .bit_in(a_din),
    .rem_out(a_rem), .rem_zero(a_zero));

  serial_fcs_engine #(.WIDTH(4), .POLY(4'b1001)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .bit_vld(b_vld), .bit_in(b_din),
    .rem_out(b_rem), .rem_zero(b_zero));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned pmod(input int unsigned v, input int total,
                                       input int unsigned pfull, input int deg);
    int unsigned x = v;
    for (int i = total - 1; i >= deg; i--)
      if (x[i]) x = x ^ (pfull << (i - deg));
    return x & ((32'd1 << deg) - 1);
  endfunction

  task automatic feed_a(input int unsigned v, input int nb);
    a_clr = 1'b1; a_vld = 1'b0;
    @(negedge clk);
    a_clr = 1'b0;
    for (int i = nb - 1; i >= 0; i--) begin
      a_vld = 1'b1; a_din = v[i];
      @(negedge clk);
    end
    a_vld = 1'b0;
  endtask

  task automatic feed_b(input int unsigned v, input int nb);
    b_clr = 1'b1; b_vld = 1'b0;
    @(negedge clk);
    b_clr = 1'b0;
    for (int i = nb - 1; i >= 0; i--) begin
      b_vld = 1'b1; b_din = v[i];
      @(negedge clk);
    end
    b_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned v;
    int unsigned cw;
    logic [4:0] held;
    rst_n = 1'b0;
    a_clr = 0; a_vld = 0; a_din = 0;
    b_clr = 0; b_vld = 0; b_din = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset a", a_rem, 0);
    chk("R1 reset b", b_rem, 0);
    chk("R9 zero after reset", a_zero, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: four bits from zero never reach bit 4
    feed_a(32'b1011, 4);
    chk("R4 plain shift", a_rem, 5'b01011);
    chk("R9 flag low on nonzero", a_zero, 0);

    // R1: synchronous clear
    a_clr = 1'b1; @(negedge clk); a_clr = 1'b0;
    chk("R1 clear", a_rem, 0);

    // R2: hold while idle with toggling data
    feed_a(32'b10111011, 8);
    held = a_rem;
    for (int i = 0; i < 6; i++) begin
      a_din = i[0];
      @(negedge clk);
      chk("R2 hold idle", a_rem, held);
    end

    // R3: clear beats a valid one-bit
    a_clr = 1'b1; a_vld = 1'b1; a_din = 1'b1;
    @(negedge clk);
    a_clr = 1'b0; a_vld = 1'b0;
    chk("R3 clear priority", a_rem, 0);

    // R5: per-bit remainder of the worked frame prefix
    a_clr = 1'b1; @(negedge clk); a_clr = 1'b0;
    for (int i = 14; i >= 0; i--) begin
      a_vld = 1'b1; a_din = v_frame(i);
      @(negedge clk);
      chk("R5 prefix remainder", a_rem,
          pmod(32'b101000110101110 >> i, 15 - i, 32'b110101, 5));
    end
    a_vld = 1'b0;
    chk("R7 worked frame zero", a_rem, 0);
    chk("R9 flag on worked frame", a_zero, 1);

    // R6: worked generation
    feed_a(32'b1010001101 << 5, 15);
    chk("R6 worked check sequence", a_rem, 5'b01110);

    // R6/R7 sweep of all 10-bit messages
    for (int d = 0; d < 1024; d++) begin
      v = pmod(d << 5, 15, 32'b110101, 5);
      feed_a(d << 5, 15);
      chk("R6 sweep generate", a_rem, v);
      feed_a((d << 5) | v, 15);
      chk("R7 sweep check", a_rem, 0);
      chk("R9 sweep flag", a_zero, 1);
    end

    // R8: single-bit flips with x^4+x^3+1
    for (int d = 0; d < 2048; d += 37) begin
      cw = (d << 4) | pmod(d << 4, 15, 32'b11001, 4);
      feed_b(cw, 15);
      chk("R7 code word b", b_rem, 0);
      for (int f = 0; f < 15; f++) begin
        feed_b(cw ^ (32'd1 << f), 15);
        chk("R8 flip nonzero", b_zero, 0);
        chk("R8 flip residue", b_rem, pmod(cw ^ (32'd1 << f), 15, 32'b11001, 4));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic v_frame(input int i);
    logic [14:0] f = 15'b101000110101110;
    return f[i];
  endfunction

endmodule